// File: doc/BRIEF.md
# Two-Class Mesh Router for Monitor Traffic

This block forwards single-flit messages across a small mesh network that carries sensor readings toward a central collector. It has up to five ports: one local injection/ejection port and up to four neighbour directions. Each input port has two virtual channels. The urgent class carries readings raised by alarm events. The normal class carries periodic samples. Each class has its own input buffer and its own credit pool toward each neighbour, so a backlog of normal traffic can never hold up an urgent flit.

A flit moves through three registered stages. First, the flit at the head of an input buffer is looked up in a small writable route table, which is indexed by the destination field, and the result is held in a per-channel lookup register. Second, every output arbitrates among the lookup registers that target it. Urgent flits are served ahead of normal ones. Among normal flits, the first requester to be checked is picked by a free-running LFSR. Third, the winner is registered onto the output bus toward the neighbour. A flit is sent only when the neighbour has a free slot on that class. Each buffer slot freed at an input returns one credit upstream.

Top module: `mon_mesh_router`

## Requirements
- R1: While reset is applied, and in the first cycle after it, `out_valid` and `credit_out` are all zero. Reset empties every buffer and sets every downstream credit count to DEPTH, so DEPTH flits per class can leave any output before any credit comes back.
- R2: A flit offered with `in_vc` = 1 (urgent) or 0 (normal) is buffered in that class and leaves with `out_vc` equal to the same value and its payload unchanged. By convention the top flit bit (FLIT_W-1) equals the class.
- R3: An uncontested flit sampled at clock edge n is visible on its output, with `out_valid` high, after edge n+2.
- R4: The output port of a flit is the table entry indexed by its destination field, which is flit bits [ADDR_W-1:0]. A destination of TBL_N or above is routed to port 0.
- R5: An entry written through `tbl_we`/`tbl_addr`/`tbl_port` at edge n is used for every lookup made at a later edge.
- R6: Each output keeps one credit count per class. A flit leaves only when the count for its class is nonzero. The count falls on each send and rises on each `credit_in` pulse. The two classes are independent, so urgent flits still leave while normal credits are exhausted.
- R7: Each flit removed from input buffer (port p, class v) produces a one-cycle pulse on `credit_out[2p+v]`. For an uncontested flit sampled at edge n, this pulse is visible after edge n+1.
- R8: When an urgent flit with credit and a normal flit both wait for the same output, the urgent flit is sent first.
- R9: Among competing normal flits, the first port checked is chosen by a free-running 8-bit LFSR, so over time every input port wins first place.
- R10: Every accepted flit leaves exactly once, on the port the table selected. No flit is dropped or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NPORTS | Flit present on each input port |
| in_vc | input | NPORTS | Class of each input flit (1 urgent, 0 normal) |
| in_flit | input | NPORTS*FLIT_W | Input flits, port p at bits [p*FLIT_W +: FLIT_W] |
| credit_out | output | 2*NPORTS | Slot-freed pulses to upstream, index 2p+class |
| out_valid | output | NPORTS | Flit present on each output port |
| out_vc | output | NPORTS | Class of each output flit |
| out_flit | output | NPORTS*FLIT_W | Output flits, same packing as inputs |
| credit_in | input | 2*NPORTS | Credits returned by neighbours, index 2p+class |
| tbl_we | input | 1 | Route table write strobe |
| tbl_addr | input | ADDR_W | Route table entry to write |
| tbl_port | input | PORT_W | Output port stored in that entry |

## Verification
The bound checker tests some rules on every cycle. It checks that outputs stay quiet straight after reset. It checks that the number of flits outstanding at each neighbour never goes above the buffer depth on either class. It checks that a credit is returned upstream only while a flit from that input channel is being held, and that the class bit of every departing flit matches its channel. Other behaviour can only be shown by the bench scenarios: exact three-stage latency, the table contents and when a rewrite takes effect, urgent flits overtaking normal ones, traffic stalling and resuming as credits are withheld and returned, and every input eventually winning a contested output.

// File: rtl/mon_mesh_pkg.sv
package mon_mesh_pkg;

   localparam int VC_N    = 2;
   localparam int LFSR_W  = 8;

   typedef enum logic {
      CLASS_NORM = 1'b0,
      CLASS_URG  = 1'b1
   } flit_class_e;

   // x^8 + x^6 + x^5 + x^4 + 1, maximal length
   function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
      return {s[LFSR_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
   endfunction

endpackage

// File: rtl/mon_mesh_vc_fifo.sv
module mon_mesh_vc_fifo #(
   parameter int W     = 24,
   parameter int DEPTH = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("mon_mesh_vc_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wp_q, rp_q;
   logic [CNT_W-1:0] cnt_q;

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] ptr);
      return (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (wr_en) wp_q <= bump(wp_q);
         if (rd_en) rp_q <= bump(rp_q);
         cnt_q <= cnt_q + CNT_W'(wr_en) - CNT_W'(rd_en);
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wp_q] <= wr_data;
   end

   assign rd_data = mem[rp_q];
   assign empty   = (cnt_q == '0);

endmodule

// File: rtl/mon_mesh_route_tbl.sv
module mon_mesh_route_tbl #(
   parameter int ENTRIES = 7,
   parameter int AW      = 3,
   parameter int PW      = 3,
   parameter int NRD     = 10
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [AW-1:0]           waddr,
   input  logic [PW-1:0]           wport,
   input  logic [NRD-1:0][AW-1:0]  raddr,
   output logic [NRD-1:0][PW-1:0]  rport
);

   if (ENTRIES > (1 << AW)) begin : g_bad_entries
      $error("mon_mesh_route_tbl: ENTRIES exceeds the address space");
   end

   logic [ENTRIES-1:0][PW-1:0] ent_q;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)                          ent_q[e] <= '0;
         else if (we && waddr == AW'(e))      ent_q[e] <= wport;
      end
   end

   // out-of-range destinations fall through to port 0
   for (genvar r = 0; r < NRD; r++) begin : g_rd
      always_comb begin
         rport[r] = '0;
         for (int e = 0; e < ENTRIES; e++) begin
            if (raddr[r] == AW'(e)) rport[r] = ent_q[e];
         end
      end
   end

endmodule

// File: rtl/mon_mesh_sw_alloc.sv
module mon_mesh_sw_alloc #(
   parameter int NP = 5,
   localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
   input  logic [NP-1:0] req_urg,
   input  logic [NP-1:0] req_norm,
   input  logic          urg_ok,
   input  logic          norm_ok,
   input  logic [PW-1:0] start,
   output logic [NP-1:0] gnt_urg,
   output logic [NP-1:0] gnt_norm,
   output logic          gnt_any,
   output logic          gnt_cls
);

   always_comb begin
      int unsigned idx;
      gnt_urg  = '0;
      gnt_norm = '0;
      gnt_any  = 1'b0;
      gnt_cls  = 1'b0;
      // urgent class first, then normal; both scan from the same random start
      for (int n = 0; n < NP; n++) begin
         idx = (int'(start) + n) % NP;
         if (!gnt_any && urg_ok && req_urg[idx]) begin
            gnt_urg[idx] = 1'b1;
            gnt_any      = 1'b1;
            gnt_cls      = 1'b1;
         end
      end
      for (int n = 0; n < NP; n++) begin
         idx = (int'(start) + n) % NP;
         if (!gnt_any && norm_ok && req_norm[idx]) begin
            gnt_norm[idx] = 1'b1;
            gnt_any       = 1'b1;
         end
      end
   end

endmodule

// File: rtl/mon_mesh_credit.sv
module mon_mesh_credit #(
   parameter int DEPTH = 4,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic give,
   output logic avail
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= CW'(DEPTH);
      end else begin
         unique case ({take, give})
            2'b10:   cnt_q <= cnt_q - 1'b1;
            2'b01:   if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign avail = (cnt_q != '0);

endmodule

// File: rtl/mon_mesh_router.sv
module mon_mesh_router
   import mon_mesh_pkg::*;
#(
   parameter int NPORTS = 5,
   parameter int FLIT_W = 24,
   parameter int DEPTH  = 4,
   parameter int TBL_N  = 7,
   parameter int ADDR_W = 3,
   localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1,
   localparam int NVC    = NPORTS * VC_N
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NPORTS-1:0]        in_valid,
   input  logic [NPORTS-1:0]        in_vc,
   input  logic [NPORTS*FLIT_W-1:0] in_flit,
   output logic [NVC-1:0]           credit_out,
   output logic [NPORTS-1:0]        out_valid,
   output logic [NPORTS-1:0]        out_vc,
   output logic [NPORTS*FLIT_W-1:0] out_flit,
   input  logic [NVC-1:0]           credit_in,
   input  logic                     tbl_we,
   input  logic [ADDR_W-1:0]        tbl_addr,
   input  logic [PORT_W-1:0]        tbl_port
);

   if (NPORTS < 2 || NPORTS > 5) begin : g_bad_ports
      $error("mon_mesh_router: NPORTS must be 2..5");
   end
   if (TBL_N < 1 || TBL_N > 7) begin : g_bad_tbl
      $error("mon_mesh_router: TBL_N must be 1..7");
   end
   if (FLIT_W < ADDR_W + 2) begin : g_bad_flit
      $error("mon_mesh_router: FLIT_W too narrow for header");
   end

   // ---------------- input buffers and lookup stage ----------------
   logic [NVC-1:0]                fifo_empty, pop, lk_valid, lk_gnt;
   logic [NVC-1:0][FLIT_W-1:0]    head, lk_flit;
   logic [NVC-1:0][ADDR_W-1:0]    head_dst;
   logic [NVC-1:0][PORT_W-1:0]    head_port, lk_port;

   for (genvar p = 0; p < NPORTS; p++) begin : g_in
      for (genvar v = 0; v < VC_N; v++) begin : g_vc
         localparam int K = p * VC_N + v;

         mon_mesh_vc_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_buf (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (in_valid[p] && (in_vc[p] == 1'(v))),
            .wr_data (in_flit[p*FLIT_W +: FLIT_W]),
            .rd_en   (pop[K]),
            .rd_data (head[K]),
            .empty   (fifo_empty[K])
         );

         assign head_dst[K] = head[K][ADDR_W-1:0];
         assign pop[K]      = !fifo_empty[K] && (!lk_valid[K] || lk_gnt[K]);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               lk_valid[K] <= 1'b0;
               lk_flit[K]  <= '0;
               lk_port[K]  <= '0;
            end else if (pop[K]) begin
               lk_valid[K] <= 1'b1;
               lk_flit[K]  <= head[K];
               lk_port[K]  <= head_port[K];
            end else if (lk_gnt[K]) begin
               lk_valid[K] <= 1'b0;
            end
         end
      end
   end

   mon_mesh_route_tbl #(
      .ENTRIES (TBL_N),
      .AW      (ADDR_W),
      .PW      (PORT_W),
      .NRD     (NVC)
   ) u_tbl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (tbl_we),
      .waddr (tbl_addr),
      .wport (tbl_port),
      .raddr (head_dst),
      .rport (head_port)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) credit_out <= '0;
      else        credit_out <= pop;
   end

   // ---------------- random start source ----------------
   logic [LFSR_W-1:0] lfsr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) lfsr_q <= LFSR_W'(1);
      else        lfsr_q <= lfsr_step(lfsr_q);
   end

   // ---------------- per-output allocation and traversal ----------------
   logic [NPORTS-1:0][NPORTS-1:0] g_urg, g_norm;

   for (genvar o = 0; o < NPORTS; o++) begin : g_out
      logic [NPORTS-1:0] rq_u, rq_n, gu, gn;
      logic              ok_u, ok_n, any, cls;
      logic [PORT_W-1:0] start;
      logic [FLIT_W-1:0] sel_flit;
      logic              ov_q, oc_q;
      logic [FLIT_W-1:0] of_q;

      always_comb begin
         for (int i = 0; i < NPORTS; i++) begin
            rq_u[i] = lk_valid[i*VC_N + 1] && (lk_port[i*VC_N + 1] == PORT_W'(o));
            rq_n[i] = lk_valid[i*VC_N]     && (lk_port[i*VC_N]     == PORT_W'(o));
         end
      end

      assign start = PORT_W'((int'(lfsr_q) + o) % NPORTS);

      mon_mesh_sw_alloc #(.NP(NPORTS)) u_alloc (
         .req_urg  (rq_u),
         .req_norm (rq_n),
         .urg_ok   (ok_u),
         .norm_ok  (ok_n),
         .start    (start),
         .gnt_urg  (gu),
         .gnt_norm (gn),
         .gnt_any  (any),
         .gnt_cls  (cls)
      );

      mon_mesh_credit #(.DEPTH(DEPTH)) u_cr_norm (
         .clk   (clk),
         .rst_n (rst_n),
         .take  (any && !cls),
         .give  (credit_in[o*VC_N]),
         .avail (ok_n)
      );

      mon_mesh_credit #(.DEPTH(DEPTH)) u_cr_urg (
         .clk   (clk),
         .rst_n (rst_n),
         .take  (any && cls),
         .give  (credit_in[o*VC_N + 1]),
         .avail (ok_u)
      );

      always_comb begin
         sel_flit = '0;
         for (int i = 0; i < NPORTS; i++) begin
            if (gu[i]) sel_flit = lk_flit[i*VC_N + 1];
            if (gn[i]) sel_flit = lk_flit[i*VC_N];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ov_q <= 1'b0;
            oc_q <= 1'b0;
            of_q <= '0;
         end else begin
            ov_q <= any;
            oc_q <= cls;
            if (any) of_q <= sel_flit;
         end
      end

      assign g_urg[o]                       = gu;
      assign g_norm[o]                      = gn;
      assign out_valid[o]                   = ov_q;
      assign out_vc[o]                      = oc_q;
      assign out_flit[o*FLIT_W +: FLIT_W]   = of_q;
   end

   always_comb begin
      lk_gnt = '0;
      for (int o = 0; o < NPORTS; o++) begin
         for (int i = 0; i < NPORTS; i++) begin
            lk_gnt[i*VC_N + 1] = lk_gnt[i*VC_N + 1] | g_urg[o][i];
            lk_gnt[i*VC_N]     = lk_gnt[i*VC_N]     | g_norm[o][i];
         end
      end
   end

endmodule

// File: rtl/mon_mesh_router_chk.sv
module mon_mesh_router_chk #(
   parameter int NPORTS = 5,
   parameter int FLIT_W = 24,
   parameter int DEPTH  = 4,
   localparam int NVC   = NPORTS * 2,
   localparam int CW    = $clog2(DEPTH + 1) + 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NPORTS-1:0]        in_valid,
   input logic [NPORTS-1:0]        in_vc,
   input logic [NVC-1:0]           credit_out,
   input logic [NPORTS-1:0]        out_valid,
   input logic [NPORTS-1:0]        out_vc,
   input logic [NPORTS*FLIT_W-1:0] out_flit,
   input logic [NVC-1:0]           credit_in
);

   logic first_q;

   always_ff @(posedge clk) begin
      if (!rst_n) first_q <= 1'b0;
      else        first_q <= 1'b1;
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !first_q |-> (out_valid == '0 && credit_out == '0))
      else $error("outputs active right after reset");

   for (genvar p = 0; p < NPORTS; p++) begin : g_p
      // R2
      class_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[p] |-> (out_flit[p*FLIT_W + FLIT_W - 1] == out_vc[p]))
         else $error("class bit and channel disagree");

      for (genvar v = 0; v < 2; v++) begin : g_v
         localparam int K = p * 2 + v;
         logic [CW-1:0] held_q, outst_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               held_q  <= '0;
               outst_q <= '0;
            end else begin
               held_q  <= held_q + CW'(in_valid[p] && in_vc[p] == 1'(v)) - CW'(credit_out[K]);
               outst_q <= outst_q + CW'(out_valid[p] && out_vc[p] == 1'(v)) - CW'(credit_in[K]);
            end
         end

         // R6
         no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            outst_q <= CW'(DEPTH))
            else $error("neighbour buffer overrun");

         // R7
         credit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            credit_out[K] |-> (held_q != '0))
            else $error("credit returned with nothing held");
      end
   end

endmodule

bind mon_mesh_router mon_mesh_router_chk #(
   .NPORTS (NPORTS),
   .FLIT_W (FLIT_W),
   .DEPTH  (DEPTH)
) u_chk (.*);

// File: tb/mon_mesh_router_tb.sv
module mon_mesh_router_tb;

   localparam int NP = 5, FW = 24, DEPTH = 4, TBL_N = 7, AW = 3, PW = 3;
   localparam int K = NP * 2;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic              rst_n;
   logic [NP-1:0]     in_valid, in_vc;
   logic [NP*FW-1:0]  in_flit;
   logic [K-1:0]      credit_out, credit_in;
   logic [NP-1:0]     out_valid, out_vc;
   logic [NP*FW-1:0]  out_flit;
   logic              tbl_we;
   logic [AW-1:0]     tbl_addr;
   logic [PW-1:0]     tbl_port;

   mon_mesh_router #(.NPORTS(NP), .FLIT_W(FW), .DEPTH(DEPTH), .TBL_N(TBL_N), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc), .in_flit(in_flit),
      .credit_out(credit_out), .out_valid(out_valid), .out_vc(out_vc), .out_flit(out_flit),
      .credit_in(credit_in), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_port(tbl_port)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   logic [FW-1:0] expq [NP][$];
   int tbl_m [8];
   int up_cred [K];
   int dn_occ [K];
   int pend [K];
   bit hold [NP];
   int out_cnt [NP];
   int seq = 0;

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   // flit: [23] class, [22:15] sequence tag, [10:8] source port, [2:0] destination
   function automatic logic [FW-1:0] mk(int vc, int src, int tag, int dst);
      logic [FW-1:0] f;
      f = '0;
      f[FW-1]    = vc[0];
      f[22:15]   = tag[7:0];
      f[10:8]    = src[2:0];
      f[AW-1:0]  = dst[AW-1:0];
      return f;
   endfunction

   // driver: stage one flit for the next edge and record where it must leave
   task automatic stage(int p, int vc, int dst);
      logic [FW-1:0] f;
      int port;
      f = mk(vc, p, seq, dst);
      seq++;
      port = (dst < TBL_N) ? tbl_m[dst] : 0;
      in_valid[p] = 1'b1;
      in_vc[p]    = vc[0];
      in_flit[p*FW +: FW] = f;
      up_cred[p*2 + vc]--;
      expq[port].push_back(f);
   endtask

   task automatic fire();
      @(posedge clk);
      @(negedge clk);
      in_valid = '0;
   endtask

   task automatic prog(int dst, int port);
      tbl_we   = 1'b1;
      tbl_addr = AW'(dst);
      tbl_port = PW'(port);
      @(posedge clk);
      @(negedge clk);
      tbl_we   = 1'b0;
      tbl_m[dst] = port;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: scoreboard compare, credit bookkeeping, downstream credit return
   always @(negedge clk) begin : mon
      logic [FW-1:0] f;
      int at, kk;
      if (rst_n && !done) begin
         for (int k = 0; k < K; k++) begin
            if (credit_out[k]) begin
               up_cred[k]++;
               check(up_cred[k] <= DEPTH, "R7", "upstream credit count", up_cred[k], DEPTH);
            end
         end
         for (int o = 0; o < NP; o++) begin
            if (out_valid[o]) begin
               f  = out_flit[o*FW +: FW];
               kk = o * 2 + int'(out_vc[o]);
               dn_occ[kk]++;
               pend[kk]++;
               out_cnt[o]++;
               check(dn_occ[kk] <= DEPTH, "R6", "neighbour occupancy", dn_occ[kk], DEPTH);
               check(f[FW-1] == out_vc[o], "R2", "class bit vs out_vc", int'(f[FW-1]), int'(out_vc[o]));
               at = -1;
               for (int j = 0; j < expq[o].size(); j++)
                  if (at < 0 && expq[o][j] == f) at = j;
               check(at >= 0, "R4", $sformatf("flit tag %0d on port %0d", f[22:15], o), at, 0);
               if (at >= 0) expq[o].delete(at);
            end
         end
         for (int k = 0; k < K; k++) begin
            credit_in[k] = 1'b0;
            if (!hold[k/2] && pend[k] > 0) begin
               credit_in[k] = 1'b1;
               pend[k]--;
               dn_occ[k]--;
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         check(0, "WDOG", "run timed out", 1, 0);
         finish_up();
      end
   end

   initial begin
      int base, first_src;
      bit seen [NP];
      rst_n = 1'b0; in_valid = '0; in_vc = '0; in_flit = '0; credit_in = '0;
      tbl_we = 1'b0; tbl_addr = '0; tbl_port = '0;
      for (int k = 0; k < K; k++) begin up_cred[k] = DEPTH; dn_occ[k] = 0; pend[k] = 0; end
      for (int o = 0; o < NP; o++) begin hold[o] = 0; out_cnt[o] = 0; seen[o] = 0; end
      for (int d = 0; d < 8; d++) tbl_m[d] = 0;

      repeat (4) @(negedge clk);
      check(out_valid == '0, "R1", "out_valid in reset", int'(out_valid), 0);
      check(credit_out == '0, "R1", "credit_out in reset", int'(credit_out), 0);
      rst_n = 1'b1;
      idle(1);
      check(out_valid == '0 && credit_out == '0, "R1", "outputs after reset", int'(out_valid), 0);

      // route table: d -> port
      prog(0, 0); prog(1, 1); prog(2, 2); prog(3, 3); prog(4, 4); prog(5, 2); prog(6, 1);

      // R3 / R7 latency of an uncontested flit
      stage(1, 0, 2);
      fire();
      check(out_valid[2] == 1'b0, "R3", "output too early (edge n)", int'(out_valid[2]), 0);
      idle(1);
      check(credit_out[2] == 1'b1, "R7", "credit pulse after edge n+1", int'(credit_out[2]), 1);
      check(out_valid[2] == 1'b0, "R3", "output too early (edge n+1)", int'(out_valid[2]), 0);
      idle(1);
      check(out_valid[2] == 1'b1, "R3", "output after edge n+2", int'(out_valid[2]), 1);
      check(out_vc[2] == 1'b0, "R2", "normal class kept", int'(out_vc[2]), 0);
      idle(4);

      // R4 each destination, including out-of-range
      for (int d = 0; d < 8; d++) begin
         int port;
         port = (d < TBL_N) ? tbl_m[d] : 0;
         base = out_cnt[port];
         stage(0, 0, d);
         fire();
         idle(5);
         check(out_cnt[port] == base + 1, "R4", $sformatf("destination %0d delivered", d), out_cnt[port] - base, 1);
      end

      // R2 urgent class kept end to end
      stage(3, 1, 1);
      fire();
      idle(2);
      check(out_valid[1] && out_vc[1] == 1'b1, "R2", "urgent class on output", int'(out_vc[1]), 1);
      idle(4);

      // R5 rewrite takes effect on the next lookup
      prog(5, 4);
      base = out_cnt[4];
      stage(2, 0, 5);
      fire();
      idle(5);
      check(out_cnt[4] == base + 1, "R5", "rewritten entry used", out_cnt[4] - base, 1);

      // R8 urgent beats normal for the same output
      stage(1, 0, 3);
      stage(2, 1, 3);
      fire();
      idle(2);
      check(out_valid[3] && out_vc[3] == 1'b1, "R8", "urgent leaves first", int'(out_vc[3]), 1);
      idle(1);
      check(out_valid[3] && out_vc[3] == 1'b0, "R8", "normal leaves next", int'(out_vc[3]), 0);
      idle(4);

      // R6 / R1 credit stall on port 4, urgent class independent
      hold[4] = 1;
      base = out_cnt[4];
      for (int p = 0; p < 4; p++) stage(p, 0, 4);
      fire();
      stage(0, 0, 4);
      stage(1, 0, 4);
      fire();
      idle(20);
      check(out_cnt[4] == base + DEPTH, "R6 R1", "normal sends stop at depth", out_cnt[4] - base, DEPTH);
      stage(2, 1, 4);
      fire();
      idle(6);
      check(out_cnt[4] == base + DEPTH + 1, "R6", "urgent passes stalled normal", out_cnt[4] - base, DEPTH + 1);
      hold[4] = 0;
      idle(20);
      check(out_cnt[4] == base + 7, "R6", "stalled flits resume", out_cnt[4] - base, 7);

      // R9 every input wins a contested output at some point
      for (int r = 0; r < 40; r++) begin
         for (int p = 0; p < NP; p++) stage(p, 0, 0);
         fire();
         idle(2);
         first_src = int'(out_flit[10:8]);
         if (out_valid[0] && first_src < NP) seen[first_src] = 1;
         idle(8 + (r % 4));
      end
      for (int p = 0; p < NP; p++)
         check(seen[p], "R9", $sformatf("input %0d won first place", p), int'(seen[p]), 1);

      // R10 nothing lost or duplicated, all credits home
      idle(20);
      for (int o = 0; o < NP; o++)
         check(expq[o].size() == 0, "R10", $sformatf("flits missing on port %0d", o), expq[o].size(), 0);
      for (int k = 0; k < K; k++)
         check(up_cred[k] == DEPTH, "R7", $sformatf("upstream credits channel %0d", k), up_cred[k], DEPTH);

      finish_up();
   end

endmodule